// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture

This peripheral stamps the arrival times of edges on a single input line. A 32-bit timestamp counter advances by one on every rising edge of the functional clock while it is allowed to run. Each qualifying edge on the capture input copies the counter into one of four capture slots. The slots fill in turn, 0, 1, 2, 3. Each slot selects its own edge direction, so one pass can time a rising edge, then a falling edge, and so on. A stop slot and a mode bit decide whether the slot sequence wraps back to slot 0 or halts after the stop slot.

Each capture and each counter wrap raises an event flag. Any flag can be enabled onto the single interrupt line. Software reaches the counter, the capture slots, the control word, the enable/flag word and a write-one-to-clear word over a simple single-cycle register bus with combinational read data.

Top module: `stamp_capture`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and the counter does not advance.
- R2: While control bit 20 (run) is 1, the counter at offset 0x00 increases by 1 every clock. While it is 0, the counter holds its value. A bus write to 0x00 loads the written value in place of the increment.
- R3: When the running counter steps from all ones to zero, event 4 (overflow) fires and sets flag bit 21 of offset 0x2C.
- R4: With control bit 8 (load enable) set, a qualifying edge copies the counter into the current slot. Slots fill in the order 0 to 3 at offsets 0x08, 0x0C, 0x10 and 0x14, and capture event n sets flag bit 17+n of 0x2C. The value stored is the counter value present two clock edges after the input changed, because the input is synchronised through two flops.
- R5: Control bit 2*i selects the edge direction for slot i: 0 means rising and 1 means falling. An edge of the other direction is ignored: the slot is not written and the sequence does not advance.
- R6: With control bit 16 at 0 (continuous), the slot after the stop slot (bits 18:17) is slot 0.
- R7: With control bit 16 at 1 (one-shot), loading halts after the stop slot is written. Any later write to the control word at 0x28 restarts the sequence at slot 0.
- R8: With load enable at 0, edges change no capture slot and set no flag.
- R9: A write to offset 0x30 with bit n+1 set clears flag n. Offset 0x30 reads as 0.
- R10: If a clear of flag n lands in the same cycle as a new event n, the flag stays set.
- R11: The enable for event n is bit n+1 of 0x2C. A global pending bit is set when an enabled event fires and is cleared by writing bit 0 of 0x30. `irq` is the global pending bit ANDed with the OR of all flags whose enable is set.
- R12: Bus writes to a capture slot load the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous signal whose edges are timed |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a flag clear that arrives in exactly the cycle a new hardware event for the same flag fires. The bench gets there with the overflow event. It loads the counter with all ones minus one, waits one idle cycle, and issues the clear write on the next edge, which is the edge where the counter wraps. Capture timing is predicted in the same way: the bench counts clock edges from the counter write and adds the two-flop synchroniser delay.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int SLOTS = 4;
  localparam int PTR_W = $clog2(SLOTS);
  localparam int EVT_N = SLOTS + 1;

  localparam logic [7:0] OFS_COUNT = 8'h00;
  localparam logic [7:0] OFS_SLOT0 = 8'h08;
  localparam logic [7:0] OFS_CTL   = 8'h28;
  localparam logic [7:0] OFS_EVT   = 8'h2C;
  localparam logic [7:0] OFS_CLR   = 8'h30;

  localparam int BIT_LOAD = 8;
  localparam int BIT_ONE  = 16;
  localparam int BIT_STOP = 17;
  localparam int BIT_RUN  = 20;
  localparam int BIT_FLAG = 17;

  typedef struct packed {
    logic [SLOTS-1:0] pol;
    logic             load_en;
    logic             oneshot;
    logic [PTR_W-1:0] stop;
    logic             run;
  } ctl_t;

  typedef struct packed {
    logic             halt;
    logic [PTR_W-1:0] nxt;
  } adv_t;

  function automatic ctl_t ctl_unpack(input logic [31:0] w);
    ctl_t c;
    for (int i = 0; i < SLOTS; i++) c.pol[i] = w[2*i];
    c.load_en = w[BIT_LOAD];
    c.oneshot = w[BIT_ONE];
    c.stop    = w[BIT_STOP +: PTR_W];
    c.run     = w[BIT_RUN];
    return c;
  endfunction

  function automatic logic [31:0] ctl_pack(input ctl_t c);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < SLOTS; i++) w[2*i] = c.pol[i];
    w[BIT_LOAD]            = c.load_en;
    w[BIT_ONE]             = c.oneshot;
    w[BIT_STOP +: PTR_W]   = c.stop;
    w[BIT_RUN]             = c.run;
    return w;
  endfunction

  // Slot sequencing after a capture into slot ptr.
  function automatic adv_t seq_advance(input logic [PTR_W-1:0] ptr,
                                       input logic [PTR_W-1:0] stop,
                                       input logic oneshot);
    adv_t a;
    if (ptr == stop) begin
      a.halt = oneshot;
      a.nxt  = oneshot ? ptr : '0;
    end else begin
      a.halt = 1'b0;
      a.nxt  = ptr + PTR_W'(1);
    end
    return a;
  endfunction
endpackage

// File: rtl/stamp_timebase.sv
module stamp_timebase #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] count_q;

  assign ovf_evt = run && !wr_en && (count_q == ALL_ONES);
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (wr_en) count_q <= wr_val;
    else if (run)   count_q <= count_q + CNT_W'(1);
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(count_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_en) |=> (count_q == $past(count_q) + CNT_W'(1))); // R2
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (count_q == '0)); // R3
endmodule

// File: rtl/stamp_sequencer.sv
module stamp_sequencer
  import stamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic [SLOTS-1:0] pol,
  input  logic             load_en,
  input  logic             oneshot,
  input  logic [PTR_W-1:0] stop,
  input  logic             rearm,
  output logic [SLOTS-1:0] load_vec
);
  logic [SYNC_STAGES:0] shift_q;
  logic [PTR_W-1:0]     ptr_q;
  logic                 halted_q;
  logic                 synced, prev, rise, fall, want, load_hit;
  adv_t                 adv;

  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], cap_in};
  end

  assign synced   = shift_q[SYNC_STAGES-1];
  assign prev     = shift_q[SYNC_STAGES];
  assign rise     = synced && !prev;
  assign fall     = !synced && prev;
  assign want     = pol[ptr_q] ? fall : rise;
  assign load_hit = load_en && !halted_q && !rearm && want;
  assign adv      = seq_advance(ptr_q, stop, oneshot);

  always_comb begin
    load_vec = '0;
    if (load_hit) load_vec[ptr_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      halted_q <= 1'b0;
    end else if (rearm) begin
      ptr_q    <= '0;
      halted_q <= 1'b0;
    end else if (load_hit) begin
      ptr_q    <= adv.nxt;
      halted_q <= adv.halt;
    end
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec)); // R4
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hit && ptr_q != stop) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R6
  AST_CONT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_hit && !oneshot && ptr_q == stop) |=> (ptr_q == '0)); // R6
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !rearm) |=> (load_vec == '0 && $stable(ptr_q))); // R7
endmodule

// File: rtl/stamp_events.sv
module stamp_events #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         en_wr,
  input  logic [N-1:0] en_val,
  input  logic         clr_wr,
  input  logic [N:0]   clr_val,
  output logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] en_q, flags_q, clr_mask;
  logic         glob_q, glob_set, glob_clr;

  assign clr_mask = clr_wr ? clr_val[N:1] : '0;
  assign glob_clr = clr_wr && clr_val[0];
  assign glob_set = |(evt & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      flags_q <= '0;
      glob_q  <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_val;
      flags_q <= (flags_q & ~clr_mask) | evt;
      if (glob_set)      glob_q <= 1'b1;
      else if (glob_clr) glob_q <= 1'b0;
    end
  end

  assign en    = en_q;
  assign flags = flags_q;
  assign irq   = glob_q && |(flags_q & en_q);

  for (genvar n = 0; n < N; n++) begin : g_flag_chk
    AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      evt[n] |=> flags_q[n]); // R10
  end
  AST_GLOBAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    glob_set |=> glob_q); // R11
endmodule

// File: rtl/stamp_capture.sv
module stamp_capture
  import stamp_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              wr_cyc;
  logic              wr_count, wr_ctl, wr_evt, wr_clr;
  logic [SLOTS-1:0]  slot_hit;
  ctl_t              ctl_q;
  logic [DATA_W-1:0] count;
  logic              ovf_evt;
  logic [SLOTS-1:0]  load_vec;
  logic [EVT_N-1:0]  evt, en, flags;
  logic [DATA_W-1:0] slot_q [SLOTS];

  assign wr_cyc   = bus_sel && bus_wr;
  assign wr_count = wr_cyc && (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_ctl   = wr_cyc && (bus_addr == ADDR_W'(OFS_CTL));
  assign wr_evt   = wr_cyc && (bus_addr == ADDR_W'(OFS_EVT));
  assign wr_clr   = wr_cyc && (bus_addr == ADDR_W'(OFS_CLR));

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (wr_ctl) ctl_q <= ctl_unpack(32'(bus_wdata));
  end

  stamp_timebase #(.CNT_W(DATA_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_q.run),
    .wr_en   (wr_count),
    .wr_val  (bus_wdata),
    .count   (count),
    .ovf_evt (ovf_evt)
  );

  stamp_sequencer #(.SYNC_STAGES(SYNC_STAGES)) u_sequencer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_in   (cap_in),
    .pol      (ctl_q.pol),
    .load_en  (ctl_q.load_en),
    .oneshot  (ctl_q.oneshot),
    .stop     (ctl_q.stop),
    .rearm    (wr_ctl),
    .load_vec (load_vec)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign slot_hit[i] = (bus_addr == ADDR_W'(OFS_SLOT0 + 8'(4 * i)));
    always_ff @(posedge clk) begin
      if (!rst_n)                       slot_q[i] <= '0;
      else if (load_vec[i])             slot_q[i] <= count;
      else if (wr_cyc && slot_hit[i])   slot_q[i] <= bus_wdata;
    end
  end

  assign evt = {ovf_evt, load_vec};

  stamp_events #(.N(EVT_N)) u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .en_wr   (wr_evt),
    .en_val  (bus_wdata[EVT_N:1]),
    .clr_wr  (wr_clr),
    .clr_val (bus_wdata[EVT_N:0]),
    .en      (en),
    .flags   (flags),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_COUNT)) bus_rdata = count;
    if (bus_addr == ADDR_W'(OFS_CTL))   bus_rdata = DATA_W'(ctl_pack(ctl_q));
    if (bus_addr == ADDR_W'(OFS_EVT)) begin
      bus_rdata[EVT_N:1]                  = en;
      bus_rdata[BIT_FLAG +: EVT_N]        = flags;
    end
    for (int i = 0; i < SLOTS; i++)
      if (slot_hit[i]) bus_rdata = slot_q[i];
  end

  AST_LOAD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_vec != '0) |-> ctl_q.load_en); // R8
  AST_SLOT_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    load_vec[0] |=> (slot_q[0] == $past(count))); // R4
endmodule

// File: tb/stamp_capture_test.sv
`timescale 1ns/100ps
module stamp_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int base_cyc = 0;
  logic [31:0] base_val = '0;
  bit done = 0;

  localparam logic [7:0] A_CNT = 8'h00, A_CTL = 8'h28, A_EVT = 8'h2C, A_CLR = 8'h30;

  stamp_capture uut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] slot_addr(int i);
    return 8'h08 + 8'(4 * i);
  endfunction

  function automatic logic [31:0] mkctl(logic [3:0] pol, logic ld, logic one,
                                        logic [1:0] stop, logic run);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) w[2*i] = pol[i];
    w[8] = ld; w[16] = one; w[18:17] = stop; w[20] = run;
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk(tag, d, exp);
  endtask

  task automatic start_run(logic [31:0] ctl, logic [31:0] c0);
    bus_write(A_CTL, ctl);
    bus_write(A_CNT, c0);
    base_val = c0;
    base_cyc = cyc;
  endtask

  task automatic clear_slots();
    for (int i = 0; i < 4; i++) bus_write(slot_addr(i), 32'h0);
    bus_write(A_CLR, 32'h3F);
  endtask

  task automatic drive_sig(logic v, output logic [31:0] expc);
    @(negedge clk);
    cap_in = v;
    expc = base_val + 32'(cyc - base_cyc) + 32'd2;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rd_chk("R1 counter", A_CNT, 0);
    for (int i = 0; i < 4; i++) rd_chk("R1 slot", slot_addr(i), 0);
    rd_chk("R1 control", A_CTL, 0);
    rd_chk("R1 evt", A_EVT, 0);
    rd_chk("R1 clr", A_CLR, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    repeat (5) @(posedge clk);
    rd_chk("R1 counter idle", A_CNT, 0);
  endtask

  task automatic t_counter();
    logic [31:0] d, frozen;
    start_run(mkctl(4'h0, 0, 0, 2'd0, 1), 32'd100);
    repeat (6) @(posedge clk);
    bus_read(A_CNT, d);
    chk("R2 running", d, base_val + 32'(cyc - base_cyc));
    bus_write(A_CTL, 32'h0);
    frozen = base_val + 32'(cyc - base_cyc);
    repeat (7) @(posedge clk);
    rd_chk("R2 frozen", A_CNT, frozen);
    bus_write(A_CNT, 32'd500);
    repeat (3) @(posedge clk);
    rd_chk("R2 load stopped", A_CNT, 32'd500);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    bus_write(A_CLR, 32'h3F);
    start_run(mkctl(4'h0, 0, 0, 2'd0, 1), 32'hFFFF_FFFD);
    bus_read(A_EVT, d);
    chk("R3 no early overflow", d, 0);
    repeat (4) @(posedge clk);
    bus_read(A_EVT, d);
    chk("R3 overflow flag", d, 32'h1 << 21);
    bus_read(A_CNT, d);
    chk("R3 wrapped count", d, base_val + 32'(cyc - base_cyc));
    bus_write(A_CLR, 32'h20);
    rd_chk("R9 flag cleared", A_EVT, 0);
  endtask

  task automatic t_slots_sw();
    for (int i = 0; i < 4; i++) bus_write(slot_addr(i), 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 4; i++) rd_chk("R12 slot write", slot_addr(i), 32'hA000_0000 + 32'(i));
  endtask

  task automatic t_continuous();
    logic [31:0] e [5];
    logic [31:0] x;
    clear_slots();
    start_run(mkctl(4'h0, 1, 0, 2'd3, 1), 32'd1000);
    for (int k = 0; k < 4; k++) begin
      drive_sig(1, e[k]);
      drive_sig(0, x);
    end
    for (int i = 0; i < 4; i++) rd_chk("R4 slot order", slot_addr(i), e[i]);
    rd_chk("R4 capture flags", A_EVT, 32'hF << 17);
    drive_sig(1, e[4]);
    rd_chk("R6 wrap to slot 0", slot_addr(0), e[4]);
    rd_chk("R6 slot 1 untouched", slot_addr(1), e[1]);
  endtask

  task automatic t_polarity();
    logic [31:0] a, b, c, d, x;
    clear_slots();
    start_run(mkctl(4'b0010, 1, 0, 2'd1, 1), 32'd2000);
    drive_sig(0, x);
    rd_chk("R5 wrong edge ignored", slot_addr(0), 0);
    rd_chk("R5 no flag on wrong edge", A_EVT, 0);
    drive_sig(1, a);
    drive_sig(0, b);
    rd_chk("R5 slot0 rising", slot_addr(0), a);
    rd_chk("R5 slot1 falling", slot_addr(1), b);
    drive_sig(1, c);
    drive_sig(0, d);
    rd_chk("R6 stop1 wrap slot0", slot_addr(0), c);
    rd_chk("R6 stop1 wrap slot1", slot_addr(1), d);
    rd_chk("R6 slot2 unused", slot_addr(2), 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] a, b, c, x;
    clear_slots();
    start_run(mkctl(4'h0, 1, 1, 2'd1, 1), 32'd3000);
    drive_sig(1, a); drive_sig(0, x);
    drive_sig(1, b); drive_sig(0, x);
    drive_sig(1, x); drive_sig(0, x);
    rd_chk("R7 slot0 held", slot_addr(0), a);
    rd_chk("R7 slot1", slot_addr(1), b);
    rd_chk("R7 slot2 not loaded", slot_addr(2), 0);
    rd_chk("R7 flags after halt", A_EVT, 32'h3 << 17);
    bus_write(A_CTL, mkctl(4'h0, 1, 1, 2'd1, 1));
    drive_sig(1, c);
    rd_chk("R7 rearm restarts slot0", slot_addr(0), c);
  endtask

  task automatic t_noload();
    logic [31:0] x;
    clear_slots();
    start_run(mkctl(4'h0, 0, 0, 2'd3, 1), 32'd4000);
    drive_sig(0, x); drive_sig(1, x);
    rd_chk("R8 slot0 unchanged", slot_addr(0), 0);
    rd_chk("R8 no flags", A_EVT, 0);
  endtask

  task automatic t_irq();
    logic [31:0] x;
    bus_write(A_CLR, 32'h3F);
    start_run(mkctl(4'h0, 1, 0, 2'd3, 1), 32'd5000);
    bus_write(A_EVT, 32'h2);
    drive_sig(0, x);
    drive_sig(1, x);
    chk("R11 irq on enabled event", {31'b0, irq}, 1);
    bus_write(A_CLR, 32'h2);
    #1 chk("R11 irq drops with flag", {31'b0, irq}, 0);
    drive_sig(0, x);
    drive_sig(1, x);
    chk("R11 disabled flag no irq", {31'b0, irq}, 0);
    bus_write(A_EVT, 32'h6);
    #1 chk("R11 enable pending with global", {31'b0, irq}, 1);
    bus_write(A_CLR, 32'h1);
    #1 chk("R11 global clear", {31'b0, irq}, 0);
    drive_sig(0, x);
    drive_sig(1, x);
    chk("R11 disabled event keeps global clear", {31'b0, irq}, 0);
    rd_chk("R9 clr reads zero", A_CLR, 0);
    bus_write(A_EVT, 32'h0);
    bus_write(A_CLR, 32'h3F);
  endtask

  task automatic t_conflict();
    logic [31:0] d;
    start_run(mkctl(4'h0, 0, 0, 2'd0, 1), 32'hFFFF_FFFE);
    repeat (3) @(posedge clk);
    bus_read(A_EVT, d);
    chk("R3 overflow before conflict", d, 32'h1 << 21);
    bus_write(A_CNT, 32'hFFFF_FFFE);
    @(posedge clk);
    bus_write(A_CLR, 32'h20);
    bus_read(A_EVT, d);
    chk("R10 event beats clear", d, 32'h1 << 21);
    bus_write(A_CLR, 32'h20);
    bus_read(A_EVT, d);
    chk("R9 plain clear", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_counter();
    t_overflow();
    t_slots_sw();
    t_continuous();
    t_polarity();
    t_oneshot();
    t_noload();
    t_irq();
    t_conflict();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired, run incomplete (R1..all) actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule